// File: doc/BRIEF.md
# Translation Renaming Stage

This stage sits between logical renaming and instruction dispatch in an out-of-order core that runs predicated code. Every cycle it takes one issue group of up to GRP instructions. Each instruction names a predicate register, NSRC source registers and at most one destination register, all as logical register numbers. Through a register alias table, the stage turns the predicate and every source into the translation register number that currently holds that logical register. Each destination gets a new translation register from a free pool. The stage also reports the number that the destination was mapped to before, so later stages can use it when an instruction is cancelled and when it commits.

The whole group is renamed as if its instructions were processed one after another. A source sees the destination of any earlier instruction in the same group. When two instructions in the group write the same register, the last one decides the mapping. This removes read-after-write and write-after-write ambiguity on logical registers.

If the pool cannot cover every destination in the group, the group is held back as a whole and nothing changes. The commit side returns old translation numbers to the pool through REL_W release lanes. Reset returns the stage to its initial state: identity map and full pool.

Top module: `trename_stage`

## Requirements
- R1: After reset, logical register r maps to translation register r. Entries LOG_REGS to TR_REGS-1 are free. No instruction is held back before the first group arrives.
- R2: `grpAccept` is a combinational output. It is 1 when at least one slot is valid and the number of free entries is at least the number of slots with both `grpValid` and `dstVld` set. On the clock edge where `grpAccept` is 1, the group is renamed. `outValid` is then 1 for exactly the following cycle.
- R3: In slot order, destinations receive the lowest-numbered free entries in ascending order. All new numbers in one group differ from each other.
- R4: The old number of a destination is the mapping of its logical register just before that instruction. This is either the table entry or the new number of an earlier writer of the same register in the group.
- R5: The predicate and the sources of slot i read the mapping left by slots 0 to i-1 of the same group. If there is no earlier writer, they read the alias table.
- R6: After a group is accepted, each logical register it wrote maps to the new number of its last writer in the group. Later groups see that mapping.
- R7: A group that is not accepted allocates nothing and leaves the map unchanged. `outValid` is 0 in the following cycle. A group with no destinations is accepted even when the pool is empty.
- R8: An entry returned on a release lane with `relValid` set can be allocated from the next cycle on.
- R9: The logical numbers of every operand, together with `outInstVld` and `outDstVld`, come out alongside the translation numbers.
- R10: A slot with `grpValid` or `dstVld` low allocates nothing and does not change the map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restores the identity map and the full pool |
| grpValid | input | GRP | Slot holds an instruction |
| predLr | input | GRP*LW | Predicate logical number per slot |
| srcLr | input | GRP*NSRC*LW | Source logical numbers; slot i, source k at bits (i*NSRC+k)*LW |
| dstVld | input | GRP | Slot writes a destination |
| dstLr | input | GRP*LW | Destination logical number per slot |
| grpAccept | output | 1 | Group is renamed at this edge |
| relValid | input | REL_W | Release lane active |
| relTrn | input | REL_W*TW | Translation number returned on each lane |
| outValid | output | 1 | Renamed group present |
| outInstVld | output | GRP | Slot valid in the renamed group |
| outPredLr | output | GRP*LW | Predicate logical numbers |
| outPredTr | output | GRP*TW | Predicate translation numbers |
| outSrcLr | output | GRP*NSRC*LW | Source logical numbers |
| outSrcTr | output | GRP*NSRC*TW | Source translation numbers |
| outDstVld | output | GRP | Slot has a destination |
| outDstLr | output | GRP*LW | Destination logical numbers |
| outDstNew | output | GRP*TW | Newly allocated translation numbers |
| outDstOld | output | GRP*TW | Previous translation numbers |

## Verification
The hardest condition to reach from the ports is a pool that holds fewer entries than a group needs, followed by the recovery after a release. To get there, the stimulus keeps issuing full groups of destinations until the pool is empty. It then offers a group with a destination, which must be held, and a group with no destination, which must still be accepted. Next it returns two superseded numbers and checks three things: a three-destination group stalls, a two-destination group receives exactly the two returned numbers, and the map is unchanged across every stall. Dependency chains inside one group, with repeated writes to the same register and the predicate reading a register written earlier in the group, are compared against a sequential reference map.

// File: rtl/trename_pkg.sv
package trename_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic accept;  // group renamed at this edge
    logic stall;   // group present but held back
  } rnStrobe_t;
endpackage

// File: rtl/trename_ctrl.sv
module trename_ctrl import trename_pkg::*; #(
  parameter int GRP      = 4,
  parameter int LOG_REGS = 32,
  parameter int TR_REGS  = 64,
  parameter int REL_W    = 2,
  localparam int TW = $clog2(TR_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRP-1:0]    grpValid,
  input  logic [GRP-1:0]    dstVld,
  input  logic [REL_W-1:0]  relValid,
  input  logic [REL_W*TW-1:0] relTrn,
  output logic [GRP*TW-1:0] allocTrn,
  output rnStrobe_t         strobe
);
  localparam int CW = $clog2(GRP + 1);
  localparam logic [TR_REGS-1:0] FREE_INIT = {TR_REGS{1'b1}} << LOG_REGS;

  logic [TR_REGS-1:0] freeMap, takeMask, relMask;
  logic [TW-1:0]      pick [GRP];
  logic [CW-1:0]      found, needCnt;
  logic [GRP-1:0]     need;

  assign need = grpValid & dstVld;

  // first GRP free entries, lowest first
  always_comb begin
    found = '0;
    for (int p = 0; p < GRP; p++) pick[p] = '0;
    for (int t = 0; t < TR_REGS; t++) begin
      if (freeMap[t] && found < CW'(GRP)) begin
        for (int p = 0; p < GRP; p++)
          if (found == CW'(p)) pick[p] = TW'(t);
        found = found + 1'b1;
      end
    end
  end

  // hand picks to destination slots in order
  always_comb begin
    needCnt  = '0;
    allocTrn = '0;
    for (int i = 0; i < GRP; i++) begin
      if (need[i]) begin
        for (int p = 0; p < GRP; p++)
          if (needCnt == CW'(p)) allocTrn[i*TW +: TW] = pick[p];
        needCnt = needCnt + 1'b1;
      end
    end
  end

  assign strobe.accept = (|grpValid) && (found >= needCnt);
  assign strobe.stall  = (|grpValid) && (found < needCnt);

  always_comb begin
    takeMask = '0;
    relMask  = '0;
    for (int i = 0; i < GRP; i++)
      if (strobe.accept && need[i]) takeMask[allocTrn[i*TW +: TW]] = 1'b1;
    for (int r = 0; r < REL_W; r++)
      if (relValid[r]) relMask[relTrn[r*TW +: TW]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) freeMap <= FREE_INIT;
    else        freeMap <= (freeMap & ~takeMask) | relMask;
  end

  for (genvar g = 0; g < GRP; g++) begin : g_allocChk
    // R3
    alloc_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe.accept && need[g]) |=> !freeMap[$past(allocTrn[g*TW +: TW])]);
  end

  for (genvar r = 0; r < REL_W; r++) begin : g_relChk
    // R8
    no_double_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      relValid[r] |-> !freeMap[relTrn[r*TW +: TW]]);
  end
endmodule

// File: rtl/trename_dp.sv
module trename_dp import trename_pkg::*; #(
  parameter int GRP      = 4,
  parameter int NSRC     = 2,
  parameter int LOG_REGS = 32,
  parameter int TR_REGS  = 64,
  localparam int LW = $clog2(LOG_REGS),
  localparam int TW = $clog2(TR_REGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  rnStrobe_t              strobe,
  input  logic [GRP-1:0]         grpValid,
  input  logic [GRP*LW-1:0]      predLr,
  input  logic [GRP*NSRC*LW-1:0] srcLr,
  input  logic [GRP-1:0]         dstVld,
  input  logic [GRP*LW-1:0]      dstLr,
  input  logic [GRP*TW-1:0]      allocTrn,
  output logic                   outValid,
  output logic [GRP-1:0]         outInstVld,
  output logic [GRP*LW-1:0]      outPredLr,
  output logic [GRP*TW-1:0]      outPredTr,
  output logic [GRP*NSRC*LW-1:0] outSrcLr,
  output logic [GRP*NSRC*TW-1:0] outSrcTr,
  output logic [GRP-1:0]         outDstVld,
  output logic [GRP*LW-1:0]      outDstLr,
  output logic [GRP*TW-1:0]      outDstNew,
  output logic [GRP*TW-1:0]      outDstOld
);
  logic [TW-1:0]        ratQ [LOG_REGS];
  logic [TW-1:0]        ratD [LOG_REGS];
  logic [GRP*TW-1:0]    predT, oldT, newT;
  logic [GRP*NSRC*TW-1:0] srcT;
  logic [GRP-1:0]       need;

  assign need = grpValid & dstVld;

  // slots walk the map in order so later slots see earlier writers
  always_comb begin
    ratD  = ratQ;
    predT = '0;
    srcT  = '0;
    oldT  = '0;
    newT  = '0;
    for (int i = 0; i < GRP; i++) begin
      predT[i*TW +: TW] = ratD[predLr[i*LW +: LW]];
      for (int k = 0; k < NSRC; k++)
        srcT[(i*NSRC+k)*TW +: TW] = ratD[srcLr[(i*NSRC+k)*LW +: LW]];
      oldT[i*TW +: TW] = ratD[dstLr[i*LW +: LW]];
      if (need[i]) begin
        newT[i*TW +: TW]          = allocTrn[i*TW +: TW];
        ratD[dstLr[i*LW +: LW]]   = allocTrn[i*TW +: TW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < LOG_REGS; r++) ratQ[r] <= TW'(r);
    end else if (strobe.accept) begin
      for (int r = 0; r < LOG_REGS; r++) ratQ[r] <= ratD[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid   <= 1'b0;
      outInstVld <= '0;
      outPredLr  <= '0;
      outPredTr  <= '0;
      outSrcLr   <= '0;
      outSrcTr   <= '0;
      outDstVld  <= '0;
      outDstLr   <= '0;
      outDstNew  <= '0;
      outDstOld  <= '0;
    end else begin
      outValid <= strobe.accept;
      if (strobe.accept) begin
        outInstVld <= grpValid;
        outPredLr  <= predLr;
        outPredTr  <= predT;
        outSrcLr   <= srcLr;
        outSrcTr   <= srcT;
        outDstVld  <= need;
        outDstLr   <= dstLr;
        outDstNew  <= newT;
        outDstOld  <= oldT;
      end
    end
  end

  // R7
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.stall |=> !outValid);

  for (genvar a = 0; a < GRP; a++) begin : g_dA
    for (genvar b = a + 1; b < GRP; b++) begin : g_dB
      // R3
      dst_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (outValid && outDstVld[a] && outDstVld[b]) |->
          (outDstNew[a*TW +: TW] != outDstNew[b*TW +: TW]));
    end
  end
endmodule

// File: rtl/trename_stage.sv
module trename_stage import trename_pkg::*; #(
  parameter int GRP      = 4,
  parameter int NSRC     = 2,
  parameter int LOG_REGS = 32,
  parameter int TR_REGS  = 64,
  parameter int REL_W    = 2,
  localparam int LW = $clog2(LOG_REGS),
  localparam int TW = $clog2(TR_REGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [GRP-1:0]         grpValid,
  input  logic [GRP*LW-1:0]      predLr,
  input  logic [GRP*NSRC*LW-1:0] srcLr,
  input  logic [GRP-1:0]         dstVld,
  input  logic [GRP*LW-1:0]      dstLr,
  output logic                   grpAccept,
  input  logic [REL_W-1:0]       relValid,
  input  logic [REL_W*TW-1:0]    relTrn,
  output logic                   outValid,
  output logic [GRP-1:0]         outInstVld,
  output logic [GRP*LW-1:0]      outPredLr,
  output logic [GRP*TW-1:0]      outPredTr,
  output logic [GRP*NSRC*LW-1:0] outSrcLr,
  output logic [GRP*NSRC*TW-1:0] outSrcTr,
  output logic [GRP-1:0]         outDstVld,
  output logic [GRP*LW-1:0]      outDstLr,
  output logic [GRP*TW-1:0]      outDstNew,
  output logic [GRP*TW-1:0]      outDstOld
);
  rnStrobe_t         strobe;
  logic [GRP*TW-1:0] allocTrn;

  assign grpAccept = strobe.accept;

  trename_ctrl #(.GRP(GRP), .LOG_REGS(LOG_REGS), .TR_REGS(TR_REGS), .REL_W(REL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .grpValid(grpValid), .dstVld(dstVld),
    .relValid(relValid), .relTrn(relTrn), .allocTrn(allocTrn), .strobe(strobe));

  trename_dp #(.GRP(GRP), .NSRC(NSRC), .LOG_REGS(LOG_REGS), .TR_REGS(TR_REGS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .grpValid(grpValid), .predLr(predLr),
    .srcLr(srcLr), .dstVld(dstVld), .dstLr(dstLr), .allocTrn(allocTrn),
    .outValid(outValid), .outInstVld(outInstVld), .outPredLr(outPredLr),
    .outPredTr(outPredTr), .outSrcLr(outSrcLr), .outSrcTr(outSrcTr),
    .outDstVld(outDstVld), .outDstLr(outDstLr), .outDstNew(outDstNew),
    .outDstOld(outDstOld));
endmodule

// File: tb/trename_stage_tb.sv
`timescale 1ns/1ps
module trename_stage_tb;
  localparam int GRP = 4, NSRC = 2, LOG_REGS = 32, TR_REGS = 64, REL_W = 2;
  localparam int LW = 5, TW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [GRP-1:0] grpValid = '0, dstVld = '0;
  logic [GRP*LW-1:0] predLr = '0, dstLr = '0;
  logic [GRP*NSRC*LW-1:0] srcLr = '0;
  logic grpAccept, outValid;
  logic [REL_W-1:0] relValid = '0;
  logic [REL_W*TW-1:0] relTrn = '0;
  logic [GRP-1:0] outInstVld, outDstVld;
  logic [GRP*LW-1:0] outPredLr, outDstLr;
  logic [GRP*TW-1:0] outPredTr, outDstNew, outDstOld;
  logic [GRP*NSRC*LW-1:0] outSrcLr;
  logic [GRP*NSRC*TW-1:0] outSrcTr;

  always #2.5 clk = ~clk;

  trename_stage u_dut (.*);

  int nChk = 0, nErr = 0;
  bit finished = 1'b0;
  int mMap [LOG_REGS];
  bit mFree [TR_REGS];
  int lastOld [GRP];
  int gv [GRP], pl [GRP], dv [GRP], dl [GRP];
  int sl [GRP][NSRC];

  task automatic chk(string req, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int freeCount();
    int c = 0;
    for (int t = 0; t < TR_REGS; t++) c += int'(mFree[t]);
    return c;
  endfunction

  task automatic clearSlots();
    for (int i = 0; i < GRP; i++) begin
      gv[i] = 0; pl[i] = 0; dv[i] = 0; dl[i] = 0;
      for (int k = 0; k < NSRC; k++) sl[i][k] = 0;
    end
  endtask

  // drive one group, compare with a sequential reference map
  task automatic runGroup(string req);
    int tMap [LOG_REGS];
    bit tFree [TR_REGS];
    int eP [GRP], eN [GRP], eO [GRP];
    int eS [GRP][NSRC];
    int needN = 0, any = 0, ok;
    tMap = mMap; tFree = mFree;
    for (int i = 0; i < GRP; i++) begin
      eP[i] = 0; eN[i] = 0; eO[i] = 0;
      for (int k = 0; k < NSRC; k++) eS[i][k] = 0;
      if (gv[i] != 0) any = 1;
      if (gv[i] != 0 && dv[i] != 0) needN++;
    end
    ok = (any != 0 && needN <= freeCount()) ? 1 : 0;
    for (int i = 0; i < GRP; i++) begin
      if (gv[i] != 0) begin
        eP[i] = tMap[pl[i]];
        for (int k = 0; k < NSRC; k++) eS[i][k] = tMap[sl[i][k]];
        if (dv[i] != 0) begin
          eO[i] = tMap[dl[i]];
          eN[i] = -1;
          for (int t = 0; t < TR_REGS; t++)
            if (tFree[t] && eN[i] < 0) eN[i] = t;
          if (eN[i] >= 0) begin tFree[eN[i]] = 1'b0; tMap[dl[i]] = eN[i]; end
        end
      end
    end
    @(negedge clk);
    for (int i = 0; i < GRP; i++) begin
      grpValid[i] = (gv[i] != 0);
      dstVld[i]   = (dv[i] != 0);
      predLr[i*LW +: LW] = LW'(pl[i]);
      dstLr[i*LW +: LW]  = LW'(dl[i]);
      for (int k = 0; k < NSRC; k++) srcLr[(i*NSRC+k)*LW +: LW] = LW'(sl[i][k]);
    end
    #1;
    chk(ok != 0 ? "R2" : "R7", {req, " grpAccept"}, int'(grpAccept), ok);
    @(negedge clk);
    grpValid = '0; dstVld = '0;
    chk(ok != 0 ? "R2" : "R7", {req, " outValid"}, int'(outValid), ok);
    if (ok != 0) begin
      for (int i = 0; i < GRP; i++) begin
        chk("R9", {req, " instVld"}, int'(outInstVld[i]), gv[i] != 0 ? 1 : 0);
        chk("R10", {req, " dstVld"}, int'(outDstVld[i]), (gv[i] != 0 && dv[i] != 0) ? 1 : 0);
        if (gv[i] != 0) begin
          chk("R9", {req, " predLr"}, int'(outPredLr[i*LW +: LW]), pl[i]);
          chk("R5", {req, " predTr"}, int'(outPredTr[i*TW +: TW]), eP[i]);
          for (int k = 0; k < NSRC; k++) begin
            chk("R9", {req, " srcLr"}, int'(outSrcLr[(i*NSRC+k)*LW +: LW]), sl[i][k]);
            chk("R5", {req, " srcTr"}, int'(outSrcTr[(i*NSRC+k)*TW +: TW]), eS[i][k]);
          end
          if (dv[i] != 0) begin
            chk("R9", {req, " dstLr"}, int'(outDstLr[i*LW +: LW]), dl[i]);
            chk("R3", {req, " dstNew"}, int'(outDstNew[i*TW +: TW]), eN[i]);
            chk("R4", {req, " dstOld"}, int'(outDstOld[i*TW +: TW]), eO[i]);
          end
        end
      end
      mMap = tMap; mFree = tFree;
      if (needN > 0) lastOld = eO;
    end
  endtask

  task automatic releasePair(int a, int b);
    @(negedge clk);
    relValid = 2'b11;
    relTrn = {TW'(b), TW'(a)};
    @(negedge clk);
    relValid = '0;
    mFree[a] = 1'b1; mFree[b] = 1'b1;
  endtask

  task automatic testReset();
    chk("R1", "outValid after reset", int'(outValid), 0);
    chk("R1", "grpAccept idle", int'(grpAccept), 0);
    clearSlots();
    for (int i = 0; i < GRP; i++) begin
      gv[i] = 1; pl[i] = i; sl[i][0] = 4 + i; sl[i][1] = 31 - i;
    end
    runGroup("R1 identity");
  endtask

  task automatic testAlloc();
    clearSlots();
    for (int i = 0; i < GRP; i++) begin
      gv[i] = 1; dv[i] = 1; dl[i] = 10 + i; pl[i] = 0; sl[i][0] = 1; sl[i][1] = 2;
    end
    runGroup("R3 first alloc");
  endtask

  task automatic testChain();
    clearSlots();
    gv[0] = 1; dv[0] = 1; dl[0] = 3; sl[0][0] = 1; sl[0][1] = 10;
    gv[1] = 1; dv[1] = 1; dl[1] = 3; pl[1] = 3; sl[1][0] = 3; sl[1][1] = 11;
    gv[2] = 1; dv[2] = 1; dl[2] = 7; sl[2][0] = 3; sl[2][1] = 3;
    gv[3] = 1; pl[3] = 7; sl[3][0] = 3; sl[3][1] = 7;
    runGroup("R5 chain");
    clearSlots();
    gv[0] = 1; pl[0] = 3; sl[0][0] = 7; sl[0][1] = 3;
    runGroup("R6 after WAW");
  endtask

  task automatic testSparse();
    clearSlots();
    gv[0] = 1; dv[0] = 0; dl[0] = 20; sl[0][0] = 20;
    gv[1] = 0; dv[1] = 1; dl[1] = 21;
    gv[2] = 1; dv[2] = 1; dl[2] = 22; sl[2][0] = 20; sl[2][1] = 21;
    gv[3] = 0; dv[3] = 1; dl[3] = 23;
    runGroup("R10 sparse");
    clearSlots();
    gv[0] = 1; sl[0][0] = 20; sl[0][1] = 21; pl[0] = 23;
    runGroup("R10 map untouched");
  endtask

  task automatic testExhaust();
    for (int n = 0; n < 16 && freeCount() >= GRP; n++) begin
      clearSlots();
      for (int i = 0; i < GRP; i++) begin
        gv[i] = 1; dv[i] = 1; dl[i] = 8 + i; sl[i][0] = 8 + i; sl[i][1] = 9;
      end
      runGroup("R3 drain");
    end
    chk("R7", "pool empty in model", freeCount(), 0);
    clearSlots();
    gv[0] = 1; dv[0] = 1; dl[0] = 12;
    runGroup("R7 stall empty");
    clearSlots();
    gv[0] = 1; sl[0][0] = 12; sl[0][1] = 8; pl[0] = 11;
    runGroup("R7 no-dest accepted");
  endtask

  task automatic testRelease();
    int a, b;
    a = lastOld[0]; b = lastOld[1];
    releasePair(a, b);
    clearSlots();
    for (int i = 0; i < 3; i++) begin gv[i] = 1; dv[i] = 1; dl[i] = 14 + i; end
    runGroup("R7 stall three");
    clearSlots();
    gv[0] = 1; dv[0] = 1; dl[0] = 14; sl[0][0] = 14;
    gv[1] = 1; dv[1] = 1; dl[1] = 14; sl[1][0] = 14;
    runGroup("R8 reuse released");
    clearSlots();
    gv[0] = 1; sl[0][0] = 14; sl[0][1] = 15; pl[0] = 16;
    runGroup("R8 map after reuse");
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      nChk++; nErr++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < LOG_REGS; r++) mMap[r] = r;
    for (int t = 0; t < TR_REGS; t++) mFree[t] = (t >= LOG_REGS);
    for (int i = 0; i < GRP; i++) lastOld[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testAlloc();
    testChain();
    testSparse();
    testExhaust();
    testRelease();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule